// File: doc/BRIEF.md
# Timer Compare Channel with Preload and Immediate-Active Pulse

This block is one compare channel of an up/down-counting timer. The counter lives outside the block. Each cycle the channel takes the counter value and compares it with an active compare value. From that result and a 4-bit output mode, it produces a registered reference level. Other logic, outside this block, turns that level into a pin signal.

Software reaches the channel through a one-cycle write port. Select 0 writes the configuration word and select 1 writes the compare value. The compare value can take effect at once. It can also be parked in a preload register and copied to the active register only when the timer's update strobe fires.

In the two PWM modes, an immediate-active option lets a trigger strobe force the reference straight to its match level. That forced level holds until the next overflow or underflow strobe, and then normal comparison resumes.

Top module: `tmr_cmp_chan`

## Requirements
- R1: After reset the mode, preload-enable and immediate-active fields are 0. The preload and active compare registers are 0, and `oref` is 0.
- R2: A configuration write (`wr_sel`=0) takes the mode low bits from `wr_data[2:0]` and the mode top bit from `wr_data[8]`. It takes preload-enable from `wr_data[3]` and immediate-active from `wr_data[6]`. All other bits are ignored.
- R3: With preload-enable clear, a compare write (`wr_sel`=1) loads the active compare value directly, and comparisons use it from the next cycle on.
- R4: With preload-enable set, a compare write goes only to the preload register. An `upd` pulse copies the preload value to the active compare value. If a compare write and `upd` occur in the same cycle, the newly written value is the one copied.
- R5: `oref` is registered: the level after a rising edge depends on the inputs and state before that edge. In mode 6 (PWM 1), `oref` is 1 when `cnt` is below the active compare value and 0 otherwise. Mode 7 (PWM 2) gives the inverse.
- R6: Modes 1, 2 and 3 set, clear and toggle `oref` when `cnt` equals the active compare value, and otherwise hold it. Mode 4 drives 0 and mode 5 drives 1. Mode 0 and codes 8 to 15 hold `oref` unchanged.
- R7: When immediate-active is set in a PWM mode, a `trig` pulse forces `oref` to the match level on the next edge, whatever the comparison gives. The match level is 1 for mode 6 and 0 for mode 7.
- R8: The forced level persists until the first cycle in which `ovf` or `udf` is high without `trig`; from the next edge the comparison rules again. A `trig` in the same cycle as `ovf` or `udf` starts, or restarts, the forced level.
- R9: `trig` has no effect when immediate-active is clear or the mode is not 6 or 7. Leaving a PWM mode or clearing immediate-active also ends any forced level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt | input | CNT_W | Current counter value |
| ovf | input | 1 | Counter overflow strobe |
| udf | input | 1 | Counter underflow strobe |
| upd | input | 1 | Update event strobe |
| trig | input | 1 | Trigger event strobe |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 1 | 0 selects the configuration word, 1 selects the compare value |
| wr_data | input | CNT_W | Write data (CNT_W must be at least 9) |
| oref | output | 1 | Reference output level |

## Verification
The assertions rely only on the strobes and the write port being sampled on the rising edge, with no constraint on how often they pulse or how they combine. The bench therefore drives every input on the falling edge. Its random phases combine trigger, overflow, underflow, update and writes freely within one cycle, including trigger together with overflow and a write together with update. The counter and compare values are kept in a narrow range so that equality matches and below/above crossings happen often, and all sixteen mode codes are visited.

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ovf,
  input  logic             udf,
  input  logic             upd,
  input  logic             trig,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             oref
);

  localparam logic [3:0] M_FROZEN = 4'd0;
  localparam logic [3:0] M_SET    = 4'd1;
  localparam logic [3:0] M_CLR    = 4'd2;
  localparam logic [3:0] M_TGL    = 4'd3;
  localparam logic [3:0] M_LOW    = 4'd4;
  localparam logic [3:0] M_HIGH   = 4'd5;
  localparam logic [3:0] M_PWM1   = 4'd6;
  localparam logic [3:0] M_PWM2   = 4'd7;

  logic [3:0]       mode;
  logic             pre_en, imm_en, hold;
  logic [CNT_W-1:0] cmp_pre, cmp_act;

  wire cfg_wr = wr_en && !wr_sel;
  wire cmp_wr = wr_en && wr_sel;
  wire is_pwm = (mode == M_PWM1) || (mode == M_PWM2);
  wire below  = cnt < cmp_act;
  wire hit    = cnt == cmp_act;
  wire hold_n = is_pwm && imm_en && (trig || (hold && !(ovf || udf)));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode   <= M_FROZEN;
      pre_en <= 1'b0;
      imm_en <= 1'b0;
    end else if (cfg_wr) begin
      mode   <= {wr_data[8], wr_data[2:0]};
      pre_en <= wr_data[3];
      imm_en <= wr_data[6];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_pre <= '0;
      cmp_act <= '0;
    end else begin
      if (cmp_wr) cmp_pre <= wr_data;
      if (cmp_wr && !pre_en)      cmp_act <= wr_data;
      else if (pre_en && upd)     cmp_act <= cmp_wr ? wr_data : cmp_pre;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold <= 1'b0;
    else        hold <= hold_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) oref <= 1'b0;
    else begin
      case (mode)
        M_SET:   if (hit) oref <= 1'b1;
        M_CLR:   if (hit) oref <= 1'b0;
        M_TGL:   if (hit) oref <= !oref;
        M_LOW:   oref <= 1'b0;
        M_HIGH:  oref <= 1'b1;
        M_PWM1:  oref <= hold_n ? 1'b1 : below;
        M_PWM2:  oref <= hold_n ? 1'b0 : !below;
        default: oref <= oref;
      endcase
    end

  p_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr && !pre_en |=> cmp_act == $past(wr_data));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_en && !upd |=> $stable(cmp_act));

  p_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_en && upd && !cmp_wr |=> cmp_act == $past(cmp_pre));

  p_pwm1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_PWM1 && !imm_en |=> oref == $past(below));

  p_force_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_HIGH |=> oref);

  p_force_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_LOW |=> !oref);

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FROZEN || mode[3]) |=> $stable(oref));

  p_imm1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_PWM1 && imm_en && trig |=> oref);

  p_imm2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_PWM2 && imm_en && trig |=> !oref);

  p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_PWM2 && !trig && (ovf || udf) |=> oref == !$past(below));

endmodule

// File: tb/tmr_cmp_chan_test.sv
module tmr_cmp_chan_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] cnt = 0, wr_data = 0;
  logic ovf = 0, udf = 0, upd = 0, trig = 0, wr_en = 0, wr_sel = 0;
  logic oref;

  int checks = 0, errors = 0;
  string focus = "R1";

  int m_mode, m_pact, m_act;
  bit m_pre, m_imm, m_hold, m_ref;

  tmr_cmp_chan #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .ovf(ovf), .udf(udf), .upd(upd),
    .trig(trig), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .oref(oref));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete (got hang, expected finish)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [W-1:0] cfgw(int mode, bit pre, bit imm);
    logic [W-1:0] v = '0;
    v[2:0] = mode[2:0];
    v[8]   = mode[3];
    v[3]   = pre;
    v[6]   = imm;
    return v;
  endfunction

  task automatic model_reset();
    m_mode = 0; m_pact = 0; m_act = 0; m_pre = 0; m_imm = 0; m_hold = 0; m_ref = 0;
  endtask

  task automatic model_step();
    bit pwm, hn, lt, eq;
    int c = int'(cnt);
    pwm = (m_mode == 6) || (m_mode == 7);
    hn  = pwm && m_imm && (trig || (m_hold && !(ovf || udf)));
    lt  = c < m_act;
    eq  = c == m_act;
    if (m_mode == 1 && eq) m_ref = 1;
    else if (m_mode == 2 && eq) m_ref = 0;
    else if (m_mode == 3 && eq) m_ref = !m_ref;
    else if (m_mode == 4) m_ref = 0;
    else if (m_mode == 5) m_ref = 1;
    else if (m_mode == 6) m_ref = hn ? 1'b1 : lt;
    else if (m_mode == 7) m_ref = hn ? 1'b0 : !lt;
    m_hold = hn;
    if (wr_en && wr_sel) begin
      if (!m_pre) m_act = int'(wr_data);
      else if (upd) m_act = int'(wr_data);
      m_pact = int'(wr_data);
    end else if (m_pre && upd) m_act = m_pact;
    if (wr_en && !wr_sel) begin
      m_mode = {wr_data[8], wr_data[2:0]};
      m_pre  = wr_data[3];
      m_imm  = wr_data[6];
    end
  endtask

  task automatic check_ref();
    checks++;
    if (oref !== m_ref) begin
      errors++;
      $display("FAIL %s at %0t: oref=%b expected %b", focus, $time, oref, m_ref);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_ref();
    wr_en = 0; upd = 0; trig = 0; ovf = 0; udf = 0;
  endtask

  task automatic wcfg(int mode, bit pre, bit imm);
    wr_en = 1; wr_sel = 0; wr_data = cfgw(mode, pre, imm); tick();
  endtask

  task automatic wcmp(int v);
    wr_en = 1; wr_sel = 1; wr_data = W'(v); tick();
  endtask

  task automatic at(int c);
    cnt = W'(c); tick();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    focus = "R1";
    check_ref();
    rst_n = 1;
    for (int i = 0; i < 4; i++) at(i);

    focus = "R2";
    wr_en = 1; wr_sel = 0; wr_data = 16'hFEB8 | cfgw(5, 0, 0); tick();
    at(3);
    wcfg(6, 0, 0);

    focus = "R3";
    wcmp(100);
    for (int c = 95; c < 106; c++) at(c);

    focus = "R5";
    for (int c = 0; c < 200; c += 7) at(c);
    wcfg(7, 0, 0);
    for (int c = 0; c < 200; c += 7) at(c);
    at(99); at(100);

    focus = "R4";
    wcfg(6, 1, 0);
    wcmp(50);
    at(70); at(70);
    upd = 1; at(70);
    at(70); at(40);
    wr_en = 1; wr_sel = 1; wr_data = 20; upd = 1; cnt = 30; tick();
    at(30); at(10);
    wcmp(200); upd = 1; at(150); at(150);

    focus = "R6";
    wcfg(0, 0, 0); wcmp(5);
    for (int m = 1; m < 16; m++) begin
      wcfg(m, 0, 0);
      for (int c = 3; c < 8; c++) at(c);
      at(5); at(5);
    end

    focus = "R7";
    wcfg(6, 0, 1); wcmp(10);
    at(20); trig = 1; at(20); at(20); at(25);
    focus = "R8";
    ovf = 1; at(20); at(20);
    trig = 1; ovf = 1; at(30); at(30);
    udf = 1; at(30); at(30);
    focus = "R7";
    wcfg(7, 0, 1);
    at(2); trig = 1; at(2); at(3);
    focus = "R8";
    udf = 1; at(2); at(2);
    focus = "R9";
    trig = 1; at(2);
    wcfg(1, 0, 1); at(2); wcfg(7, 0, 1); at(2);
    wcfg(7, 0, 0); trig = 1; at(2); at(2);
    wcfg(5, 0, 1); trig = 1; at(20); wcfg(2, 0, 1); trig = 1; at(7); at(10);

    focus = "R6";
    for (int i = 0; i < 3000; i++) begin
      if (i % 600 == 0) focus = (i % 1200 == 0) ? "R8" : "R4";
      if (($urandom % 8) == 0) begin
        wr_en = 1; wr_sel = 0;
        wr_data = cfgw($urandom % 16, $urandom % 2, $urandom % 2);
        if (($urandom % 4) == 0) wr_data[15:9] = 7'($urandom);
      end else if (($urandom % 6) == 0) begin
        wr_en = 1; wr_sel = 1; wr_data = W'($urandom % 16);
      end
      upd  = ($urandom % 5) == 0;
      trig = ($urandom % 7) == 0;
      ovf  = ($urandom % 6) == 0;
      udf  = ($urandom % 9) == 0;
      cnt  = W'($urandom % 16);
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule